// File: doc/BRIEF.md
# Two-wire management link read master

This block performs register reads over a two-wire serial management link. The link has a clock output and one data line. The data line is bidirectional, and the block controls it with an output value and an output enable. A host places a 16-bit register address on `addr_i` and pulses `start_i` for one cycle.

The block then sends a sequence on the link:
- a 1-0-1 start pattern, with no preamble;
- a command byte;
- the address, low byte first.

After the address it releases the data line for one bit slot. It then samples 16 data bits, low byte first. Finally it drives a 0-1 stop pattern and gives one extra clock pulse.

The assembled data appears on `rdata_o` together with a single-cycle `done_o`. `busy_o` is high for the whole transaction. The bit rate comes from `div_i`, which is the number of system clock cycles per half period of the link clock.

Top module: `smi_rd_master`

## Requirements
- R1: After reset and between transactions: `sck_o` is low, `sda_oe_o` is 0 and `busy_o` is 0.
- R2: A `start_i` pulse while idle sets `busy_o` in the next cycle. A `start_i` pulse while `busy_o` is high is ignored: it does not change the address sent and does not start a second transaction.
- R3: The first slots on the data line carry 1, 0, 1, then the command byte. The command byte is parameter `CMD_BYTE` (default 0xA9) and is sent most significant bit first.
- R4: The address follows the command as two bytes: bits 7:0 first, then bits 15:8, each byte most significant bit first.
- R5: The output enable is 0 in slot 27 (turnaround) and in the 16 read slots 28 to 43. It is 1 in every other slot of a transaction.
- R6: Data is sampled on rising `sck_o` edges in slots 28 to 43. The first 8 bits received form `rdata_o[7:0]` and the next 8 form `rdata_o[15:8]`, each byte most significant bit first.
- R7: Slot 44 carries 0 and slot 45 carries 1. Slot 46 is an extra clock pulse, so every transaction has exactly 47 rising `sck_o` edges.
- R8: Each half period of `sck_o` lasts `div_i` system cycles, and a value of 0 acts as 1. `div_i` is taken at start. `busy_o` stays high for 94 × half-period cycles.
- R9: `done_o` is high for exactly one cycle, with `busy_o` already low. `rdata_o` changes only in a cycle in which `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for one read |
| addr_i | input | 16 | Register address |
| div_i | input | DIV_W | System cycles per half link-clock period |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read result |
| sck_o | output | 1 | Link clock |
| sda_o | output | 1 | Data line output value |
| sda_oe_o | output | 1 | Data line output enable |
| sda_i | input | 1 | Data line input value |

## Verification
`busy_o` rises on the first clock edge after the strobe. The first `sck_o` rise comes `div_i` cycles after that, and `done_o` comes 94 × `div_i` cycles after `busy_o` rose. The bench counts these cycles at falling system clock edges and compares the count with 94 × `div_i`.

A slave model in the bench keys everything off rising `sck_o` edges:
- it counts the rising edges and captures the outgoing bits and the output enable on each one;
- it presents each read bit on the falling `sck_o` edge before the slot in which that bit is sampled.

A scoreboard queue holds the expected address and data for each transaction. At each `done_o`, the bench pops the queue and compares the entries with `rdata_o` and with what the slave decoded.

// File: rtl/smi_pkg.sv
package smi_pkg;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 16;
  localparam int CMD_W     = 8;
  localparam int SYNC_W    = 3;
  localparam int TX_BITS   = SYNC_W + CMD_W + ADDR_W;   // 27
  localparam int SLOT_TURN = TX_BITS;                   // 27
  localparam int SLOT_RX0  = SLOT_TURN + 1;             // 28
  localparam int SLOT_STOP = SLOT_RX0 + DATA_W;         // 44
  localparam int SLOT_LAST = SLOT_STOP + 2;             // 46
  localparam int SLOT_W    = $clog2(SLOT_LAST + 1);

  typedef enum logic {ST_IDLE, ST_RUN} smi_state_e;
endpackage

// File: rtl/smi_div.sv
module smi_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] lim_q, cnt_q;

  assign tick_o = run_i && (cnt_q == lim_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      lim_q <= (div_i == '0) ? '0 : div_i - 1'b1;
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/smi_txsr.sv
module smi_txsr #(
  parameter int W = 27
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         shift_i,
  output logic         msb_o
);
  logic [W-1:0] sr_q;

  assign msb_o = sr_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= data_i;
    else if (shift_i) sr_q <= {sr_q[W-2:0], 1'b0};
  end
endmodule

// File: rtl/smi_rxsr.sv
module smi_rxsr #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sample_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o
);
  localparam int HB = W / 2;
  logic [W-1:0] sr_q;

  // first byte received is the low byte
  assign data_o = {sr_q[HB-1:0], sr_q[W-1:HB]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '0;
    else if (sample_i) sr_q <= {sr_q[W-2:0], bit_i};
  end
endmodule

// File: rtl/smi_rd_master.sv
module smi_rd_master
  import smi_pkg::*;
#(
  parameter logic [7:0] CMD_BYTE = 8'hA9,
  parameter int         DIV_W    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DIV_W-1:0]    div_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                sck_o,
  output logic                sda_o,
  output logic                sda_oe_o,
  input  logic                sda_i
);
  localparam logic [SLOT_W-1:0] S_TX   = SLOT_W'(TX_BITS);
  localparam logic [SLOT_W-1:0] S_RX0  = SLOT_W'(SLOT_RX0);
  localparam logic [SLOT_W-1:0] S_STOP = SLOT_W'(SLOT_STOP);
  localparam logic [SLOT_W-1:0] S_LAST = SLOT_W'(SLOT_LAST);
  localparam logic [2:0]        SYNC   = 3'b101;

  smi_state_e        state_q;
  logic [SLOT_W-1:0] slot_q;
  logic              half_q, sck_q, done_q;
  logic [DATA_W-1:0] rdata_q;
  logic              tick, load, run, tx_bit, tx_shift, rx_sample;
  logic [DATA_W-1:0] rx_data;
  logic [TX_BITS-1:0] tx_frame;

  assign run       = (state_q == ST_RUN);
  assign load      = (state_q == ST_IDLE) && start_i;
  assign tx_frame  = {SYNC, CMD_BYTE, addr_i[7:0], addr_i[15:8]};
  assign tx_shift  = run && tick && half_q && (slot_q < S_TX);
  assign rx_sample = run && tick && !half_q && (slot_q >= S_RX0) && (slot_q < S_STOP);

  smi_div #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .load_i(load), .run_i(run), .div_i, .tick_o(tick)
  );

  smi_txsr #(.W(TX_BITS)) u_tx (
    .clk_i, .rst_ni, .load_i(load), .data_i(tx_frame),
    .shift_i(tx_shift), .msb_o(tx_bit)
  );

  smi_rxsr #(.W(DATA_W)) u_rx (
    .clk_i, .rst_ni, .sample_i(rx_sample), .bit_i(sda_i), .data_o(rx_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      half_q  <= 1'b0;
      sck_q   <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          slot_q  <= '0;
          half_q  <= 1'b0;
          sck_q   <= 1'b0;
        end
        ST_RUN: if (tick) begin
          if (!half_q) begin
            half_q <= 1'b1;
            sck_q  <= 1'b1;
          end else begin
            half_q <= 1'b0;
            sck_q  <= 1'b0;
            if (slot_q == S_LAST) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              rdata_q <= rx_data;
            end else begin
              slot_q <= slot_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // slot 44 drives the stop low bit; 45 and the extra pulse drive high
  always_comb begin
    if (!run)                sda_o = 1'b0;
    else if (slot_q < S_TX)  sda_o = tx_bit;
    else if (slot_q == S_STOP) sda_o = 1'b0;
    else                     sda_o = 1'b1;
  end

  assign sda_oe_o = run && !((slot_q >= S_TX) && (slot_q < S_STOP));
  assign busy_o   = run;
  assign done_o   = done_q;
  assign rdata_o  = rdata_q;
  assign sck_o    = sck_q;
endmodule

// File: rtl/smi_rd_master_chk.sv
module smi_rd_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic [15:0] rdata_o,
  input logic        sck_o,
  input logic        sda_oe_o
);
  // R1
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sck_o && !sda_oe_o));

  // R2
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R9
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> done_o);

  // R7
  sck_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sck_o) |-> (busy_o || done_o));
endmodule

bind smi_rd_master smi_rd_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .rdata_o(rdata_o), .sck_o(sck_o), .sda_oe_o(sda_oe_o)
);

// File: tb/smi_rd_master_bench.sv
module smi_rd_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  div = 8'd1;
  logic        busy, done, sck, sda_out, sda_oe;
  logic        sda_in = 1'b1;
  logic [15:0] rdata;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  smi_rd_master u_smi_rd_master (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .div_i(div),
    .busy_o(busy), .done_o(done), .rdata_o(rdata), .sck_o(sck),
    .sda_o(sda_out), .sda_oe_o(sda_oe), .sda_i(sda_in)
  );

  function automatic logic [15:0] slave_val(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h1234;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // slave model
  int          rises = 0;
  int          last_rises = 0;
  int          oe_err = 0;
  int          stop_err = 0;
  logic [26:0] cap = '0;
  logic [2:0]  s_sync;
  logic [7:0]  s_cmd;
  logic [15:0] s_addr, s_data;

  always @(posedge sck or negedge sck) begin
    if (sck) begin
      rises++;
      if (sda_oe !== ((rises <= 27) || (rises >= 45))) oe_err++;
      if (rises <= 27) cap = {cap[25:0], sda_out};
      if (rises == 27) begin
        s_sync = cap[26:24];
        s_cmd  = cap[23:16];
        s_addr = {cap[7:0], cap[15:8]};
        s_data = slave_val(s_addr);
      end
      if (rises == 45 && sda_out !== 1'b0) stop_err++;
      if (rises == 46 && sda_out !== 1'b1) stop_err++;
      if (rises == 47) begin
        last_rises = rises;
        rises = 0;
      end
    end else if (rises >= 28 && rises <= 43) begin
      sda_in = {s_data[7:0], s_data[15:8]}[15 - (rises - 28)];
    end
  end

  // sck high-time measurement
  int hi_cnt = 0;
  int last_hi = 0;
  always @(negedge clk) begin
    if (sck) hi_cnt++;
    else if (hi_cnt != 0) begin
      last_hi = hi_cnt;
      hi_cnt = 0;
    end
  end

  // scoreboard
  logic [15:0] exp_addr_q[$];
  logic [15:0] exp_data_q[$];
  int          done_seen = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        logic [15:0] ea, ed;
        done_seen++;
        ea = exp_addr_q.pop_front();
        ed = exp_data_q.pop_front();
        chk(s_sync == 3'b101, "R3 sync", s_sync, 3'b101);
        chk(s_cmd == 8'hA9, "R3 cmd", s_cmd, 8'hA9);
        chk(s_addr == ea, "R4 addr", s_addr, ea);
        chk(oe_err == 0, "R5 oe", oe_err, 0);
        chk(rdata == ed, "R6 rdata", rdata, ed);
        chk(stop_err == 0, "R7 stop", stop_err, 0);
        chk(last_rises == 47 && rises == 0, "R7 rises", last_rises, 47);
        chk(!busy, "R9 busy at done", busy, 0);
        oe_err = 0;
        stop_err = 0;
        @(negedge clk);
        chk(!done, "R9 pulse", done, 0);
      end
    end
  end

  task automatic do_read(input logic [15:0] a, input logic [7:0] d, input bit poke);
    int n = 0;
    int deff;
    deff = (d == 0) ? 1 : int'(d);
    @(negedge clk);
    addr = a;
    div = d;
    start = 1'b1;
    exp_addr_q.push_back(a);
    exp_data_q.push_back(slave_val(a));
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R2 busy", busy, 1);
    while (busy) begin
      n++;
      if (poke && n == 20) begin
        addr = 16'hFFFF;
        start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(n == 94 * deff, "R8 busy len", n, 94 * deff);
    chk(last_hi == deff, "R8 sck high", last_hi, deff);
    repeat (3) @(negedge clk);
    chk(!busy && !sck && !sda_oe, "R1 idle", {busy, sck, sda_oe}, 0);
    if (poke) chk(!busy, "R2 ignored start", busy, 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    chk(!busy && !sck && !sda_oe && !done && rdata == 0, "R1 reset",
        {busy, sck, sda_oe, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    do_read(16'h0102, 8'd1, 1'b0);
    do_read(16'hA55A, 8'd2, 1'b0);
    do_read(16'h8001, 8'd3, 1'b1);
    do_read(16'hFFFF, 8'd0, 1'b0);
    do_read(16'h0000, 8'd5, 1'b0);
    held = rdata;
    repeat (30) @(negedge clk);
    chk(rdata == held, "R9 hold", rdata, held);
    chk(done_seen == 5, "R2 txn count", done_seen, 5);
    finish_run();
  end
endmodule